// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block makes the strobes and port drive selections for the multiplexed external memory bus of a small 8-bit controller. A sequencer outside the block supplies the state index within the six-state machine cycle. From it the block produces the address latch enable pulse (active high), the program-store read strobe (active low), a select code for the low-order address/data port, and the byte shown on the high-order address port.

Inputs say whether code is fetched from external memory, whether a MOVX external data access is under way and whether the current machine cycle is its data cycle, whether that access uses a 16-bit pointer or an 8-bit register, whether a MOVC access is under way, and whether the ALE-disable control bit is set. The block also takes the high-order port's own latch value, the data pointer high byte and the program counter high byte. Each output is registered and shows the effect of the inputs sampled at the previous clock edge.

Top module: `bus_strobe_gen`

## Requirements
- R1: When reset is high (synchronous), the outputs go to ale_o=0, psen_n_o=1, p0_sel_o=0 (float) and p2_o=8'hFF.
- R2: Every output reflects the inputs sampled one clock edge earlier. ale_o goes high for one clock after st_i equals 1 or 4, unless R3 or R4 blocks it.
- R3: In the data cycle of a MOVX access (xdat_i=1), the ALE pulse that follows state 1 is omitted. The pulse that follows state 4 still occurs.
- R4: With ale_dis_i=1, ext_exec_i=0, movx_i=0 and movc_i=0, ale_o stays low in every state.
- R5: When ext_exec_i=1, ale_dis_i has no effect: ALE pulses as in R2 and R3.
- R6: With ext_exec_i=1, psen_n_o goes low for one clock after st_i equals 2 or 5, and it is never low in the same cycle as ale_o is high.
- R7: In a MOVX data cycle (xdat_i=1), psen_n_o stays high.
- R8: With ext_exec_i=0, psen_n_o stays high.
- R9: While movx_i=1, p2_o shows dph_i if ptr16_i=1 and p2_latch_i if ptr16_i=0.
- R10: While movx_i=0, p2_o shows pch_i if ext_exec_i=1 and p2_latch_i otherwise.
- R11: p0_sel_o is 1 (drive the address) in each cycle in which ale_o is high. It is 2 (drive data) after states 2 and 3 of a MOVX data cycle. In every other cycle it is 0 (float).
- R12: State values 6 and 7 produce no ALE or PSEN pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| st_i | input | 3 | State index within the machine cycle (0..5) |
| ext_exec_i | input | 1 | Code is fetched from external memory |
| movx_i | input | 1 | MOVX external data access under way (both cycles) |
| xdat_i | input | 1 | Current cycle is the MOVX data cycle |
| ptr16_i | input | 1 | MOVX uses a 16-bit pointer (1) or an 8-bit register (0) |
| movc_i | input | 1 | MOVC access under way |
| ale_dis_i | input | 1 | ALE-disable control bit |
| p2_latch_i | input | 8 | High-order port latch value |
| dph_i | input | 8 | Data pointer high byte |
| pch_i | input | 8 | Program counter high byte |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| p0_sel_o | output | 2 | Low port select: 0 float, 1 address, 2 data |
| p2_o | output | 8 | Byte driven on the high-order port |

## Verification
The hardest case to reach is a MOVX data cycle that falls while ALE is disabled and code runs internally. Here three rules meet: the MOVX override of the disable bit, the skipped first pulse, and the absence of PSEN. The random stimulus therefore builds whole two-cycle MOVX accesses and draws the disable bit and the execution source independently for each access. Directed runs add long stretches with ALE disabled, external execution with the disable bit set, and the unused state codes 6 and 7.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  typedef enum logic [1:0] {
    P0_FLOAT = 2'd0,
    P0_ADDR  = 2'd1,
    P0_DATA  = 2'd2
  } p0_sel_e;
endpackage

// File: rtl/ale_gen.sv
module ale_gen #(
  parameter int ST_W  = 3,
  parameter int ALE_A = 1,
  parameter int ALE_B = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_i,
  input  logic            ext_exec_i,
  input  logic            movx_i,
  input  logic            movc_i,
  input  logic            xdat_i,
  input  logic            ale_dis_i,
  output logic            ale_nxt_o,
  output logic            ale_o
);
  logic slot_a, slot_b, allow;

  always_comb begin
    slot_a    = (st_i == ST_W'(ALE_A)) && !xdat_i;
    slot_b    = (st_i == ST_W'(ALE_B));
    allow     = ext_exec_i || !ale_dis_i || movx_i || movc_i;
    ale_nxt_o = allow && (slot_a || slot_b);
  end

  always_ff @(posedge clk) begin
    if (rst) ale_o <= 1'b0;
    else     ale_o <= ale_nxt_o;
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_ale_slot_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    ale_o |-> ($past(st_i) == ST_W'(ALE_A) || $past(st_i) == ST_W'(ALE_B)));
  assert_ale_skip_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(xdat_i) && $past(st_i) == ST_W'(ALE_A)) |-> !ale_o);
  assert_ale_off_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ale_dis_i) && !$past(ext_exec_i) && !$past(movx_i) && !$past(movc_i)) |-> !ale_o);
endmodule

// File: rtl/psen_gen.sv
module psen_gen #(
  parameter int ST_W   = 3,
  parameter int PSEN_A = 2,
  parameter int PSEN_B = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_i,
  input  logic            ext_exec_i,
  input  logic            xdat_i,
  output logic            psen_n_o
);
  logic rd_slot;

  always_comb
    rd_slot = ext_exec_i && !xdat_i &&
              ((st_i == ST_W'(PSEN_A)) || (st_i == ST_W'(PSEN_B)));

  always_ff @(posedge clk) begin
    if (rst) psen_n_o <= 1'b1;
    else     psen_n_o <= !rd_slot;
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_psen_xdat_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(xdat_i) |-> psen_n_o);
  assert_psen_int_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(ext_exec_i) |-> psen_n_o);
endmodule

// File: rtl/port_mux.sv
module port_mux
  import bus_strobe_pkg::*;
#(
  parameter int ST_W   = 3,
  parameter int DW     = 8,
  parameter int DATA_A = 2,
  parameter int DATA_B = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_i,
  input  logic            ale_nxt_i,
  input  logic            ext_exec_i,
  input  logic            movx_i,
  input  logic            xdat_i,
  input  logic            ptr16_i,
  input  logic [DW-1:0]   p2_latch_i,
  input  logic [DW-1:0]   dph_i,
  input  logic [DW-1:0]   pch_i,
  output p0_sel_e         p0_sel_o,
  output logic [DW-1:0]   p2_o
);
  p0_sel_e     p0_nxt;
  logic [DW-1:0] p2_nxt;

  always_comb begin
    if (ale_nxt_i)
      p0_nxt = P0_ADDR;
    else if (xdat_i && (st_i == ST_W'(DATA_A) || st_i == ST_W'(DATA_B)))
      p0_nxt = P0_DATA;
    else
      p0_nxt = P0_FLOAT;

    if (movx_i)          p2_nxt = ptr16_i ? dph_i : p2_latch_i;
    else if (ext_exec_i) p2_nxt = pch_i;
    else                 p2_nxt = p2_latch_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_sel_o <= P0_FLOAT;
      p2_o     <= {DW{1'b1}};
    end else begin
      p0_sel_o <= p0_nxt;
      p2_o     <= p2_nxt;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_p2_ptr16_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(movx_i) && $past(ptr16_i)) |-> (p2_o == $past(dph_i)));
  assert_p2_reg8_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(movx_i) && !$past(ptr16_i)) |-> (p2_o == $past(p2_latch_i)));
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen #(
  parameter int ST_W   = 3,
  parameter int DW     = 8,
  parameter int ALE_A  = 1,
  parameter int ALE_B  = 4,
  parameter int PSEN_A = 2,
  parameter int PSEN_B = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_i,
  input  logic            ext_exec_i,
  input  logic            movx_i,
  input  logic            xdat_i,
  input  logic            ptr16_i,
  input  logic            movc_i,
  input  logic            ale_dis_i,
  input  logic [DW-1:0]   p2_latch_i,
  input  logic [DW-1:0]   dph_i,
  input  logic [DW-1:0]   pch_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic [1:0]      p0_sel_o,
  output logic [DW-1:0]   p2_o
);
  import bus_strobe_pkg::*;

  logic    ale_nxt;
  p0_sel_e p0_sel;

  ale_gen #(.ST_W(ST_W), .ALE_A(ALE_A), .ALE_B(ALE_B)) u_ale (
    .clk(clk), .rst(rst), .st_i(st_i), .ext_exec_i(ext_exec_i),
    .movx_i(movx_i), .movc_i(movc_i), .xdat_i(xdat_i),
    .ale_dis_i(ale_dis_i), .ale_nxt_o(ale_nxt), .ale_o(ale_o)
  );

  psen_gen #(.ST_W(ST_W), .PSEN_A(PSEN_A), .PSEN_B(PSEN_B)) u_psen (
    .clk(clk), .rst(rst), .st_i(st_i), .ext_exec_i(ext_exec_i),
    .xdat_i(xdat_i), .psen_n_o(psen_n_o)
  );

  port_mux #(.ST_W(ST_W), .DW(DW), .DATA_A(PSEN_A), .DATA_B(PSEN_A + 1)) u_port (
    .clk(clk), .rst(rst), .st_i(st_i), .ale_nxt_i(ale_nxt),
    .ext_exec_i(ext_exec_i), .movx_i(movx_i), .xdat_i(xdat_i),
    .ptr16_i(ptr16_i), .p2_latch_i(p2_latch_i), .dph_i(dph_i),
    .pch_i(pch_i), .p0_sel_o(p0_sel), .p2_o(p2_o)
  );

  assign p0_sel_o = p0_sel;

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !(ale_o && !psen_n_o));
  assert_p0_addr_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    ale_o |-> (p0_sel_o == 2'd1));
  assert_idle_st_R12: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(st_i) > 3'd5) |-> (!ale_o && psen_n_o));
endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] st = 3'd0;
  logic       ext = 0, movx = 0, xdat = 0, ptr16 = 0, movc = 0, dis = 0;
  logic [7:0] lat = 8'h00, dph = 8'h00, pch = 8'h00;
  logic       ale, psen_n;
  logic [1:0] p0;
  logic [7:0] p2;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_strobe_gen u_dut (
    .clk(clk), .rst(rst), .st_i(st), .ext_exec_i(ext), .movx_i(movx),
    .xdat_i(xdat), .ptr16_i(ptr16), .movc_i(movc), .ale_dis_i(dis),
    .p2_latch_i(lat), .dph_i(dph), .pch_i(pch),
    .ale_o(ale), .psen_n_o(psen_n), .p0_sel_o(p0), .p2_o(p2)
  );

  function automatic logic f_ale();
    logic allow = ext || !dis || movx || movc;
    return allow && ((st == 3'd1 && !xdat) || st == 3'd4);
  endfunction
  function automatic logic f_psen_n();
    return !(ext && !xdat && (st == 3'd2 || st == 3'd5));
  endfunction
  function automatic logic [1:0] f_p0();
    if (f_ale()) return 2'd1;
    if (xdat && (st == 3'd2 || st == 3'd3)) return 2'd2;
    return 2'd0;
  endfunction
  function automatic logic [7:0] f_p2();
    if (movx) return ptr16 ? dph : lat;
    if (ext) return pch;
    return lat;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s st=%0d actual=%h expected=%h", req, st, act, exp);
    end
  endtask

  task automatic step();
    logic a = f_ale(), pn = f_psen_n();
    logic [1:0] q0 = f_p0();
    logic [7:0] q2 = f_p2();
    string ra = xdat ? "R3" : (dis && !ext) ? ((movx || movc) ? "R2" : "R4") : (ext ? "R5" : "R2");
    string rp = xdat ? "R7" : (ext ? "R6" : "R8");
    @(negedge clk);
    chk((st > 3'd5) ? "R12" : ra, {7'd0, ale}, {7'd0, a});
    chk(rp, {7'd0, psen_n}, {7'd0, pn});
    chk("R11", {6'd0, p0}, {6'd0, q0});
    chk(movx ? "R9" : "R10", p2, q2);
    if (ale && !psen_n) chk("R6", 8'd1, 8'd0);
  endtask

  task automatic mcycle(input logic e, input logic mx, input logic xd, input logic pt,
                        input logic mc, input logic d);
    for (int s = 0; s < 6; s++) begin
      st = 3'(s); ext = e; movx = mx; xdat = xd; ptr16 = pt; movc = mc; dis = d;
      lat = 8'($urandom); dph = 8'($urandom); pch = 8'($urandom);
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {7'd0, ale}, 8'd0);
    chk("R1", {7'd0, psen_n}, 8'd1);
    chk("R1", {6'd0, p0}, 8'd0);
    chk("R1", p2, 8'hFF);
    rst = 1'b0;
    // directed: disabled ALE, internal code (R4), then disable ignored under external code (R5)
    mcycle(0, 0, 0, 0, 0, 1);
    mcycle(0, 0, 0, 0, 1, 1);
    mcycle(1, 0, 0, 0, 0, 1);
    // MOVX with ALE disabled and internal execution: both cycles (R3, R7, R9)
    mcycle(0, 1, 0, 0, 0, 1);
    mcycle(0, 1, 1, 0, 0, 1);
    mcycle(1, 1, 0, 1, 0, 0);
    mcycle(1, 1, 1, 1, 0, 0);
    // unused state codes (R12)
    for (int k = 6; k < 8; k++) begin
      st = 3'(k); ext = 1; dis = 0; movx = 0; xdat = 0; movc = 0;
      step();
    end
    // random machine cycles; MOVX always as a two-cycle pair
    for (int n = 0; n < 300; n++) begin
      logic e = 1'($urandom), d = 1'($urandom), pt = 1'($urandom), mc = 1'($urandom);
      if ($urandom % 3 == 0) begin
        mcycle(e, 1, 0, pt, 0, d);
        mcycle(e, 1, 1, pt, 0, d);
      end else begin
        mcycle(e, 0, 0, 0, mc, d);
      end
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule